// File: doc/BRIEF.md
# SPI Slave with Idle-Pattern FIFOs

This block is a byte-oriented SPI slave for a system that exchanges data with an external host. SCK, chip select and MOSI are brought into the system clock domain and oversampled. The host clocks full-duplex bytes, most significant bit first. For every byte shifted in on MOSI, one byte is shifted out on MISO. Outgoing bytes come from a transmit FIFO while that FIFO is enabled and holds data. At all other times MISO carries a two-byte idle pattern that alternates byte by byte.

On the receive side, bytes land in a receive FIFO. A host that polls by sending idle filler would fill that FIFO with useless bytes. To stop this, a filter counts consecutive bytes that follow the idle pattern. Once a programmable number of them have been stored, it discards further matching bytes. It stores again as soon as a byte breaks the pattern.

The system side works through a small write-only configuration port and a push/pop pair per FIFO. The status outputs are fill levels, threshold interrupts, a transmit-drained flag, and sticky framing and overflow errors.

Top module: `spi_idle_slave`

## Requirements
- R1: SPI mode 1 with MSB first. MISO changes only in response to a rising SCK edge. MOSI is sampled on falling SCK edges, so a MOSI change made while SCK is high is the value captured.
- R2: Every 8 falling SCK edges while chip select is low complete one received byte. Stored bytes leave the RX FIFO in arrival order. `rx_rdata` shows the oldest byte, and a one-cycle `rx_pop` removes it.
- R3: When the TX FIFO is not used, MISO sends idle byte 0 and idle byte 1 alternately. These bytes are written at `cfg_addr` 0 and 1 and reset to 0xA7 and 0xB4.
- R4: The idle alternation restarts with idle byte 0 on the first byte after each chip-select assertion. It advances only on bytes that actually send idle.
- R5: Writing `cfg_addr` 5 with bit 0 set enables the TX FIFO (`tx_en`=1). While enabled and non-empty, each byte slot pops and sends the oldest pushed byte.
- R6: The TX FIFO disables itself (`tx_en` falls) when its last byte is taken, or when a byte slot finds it enabled but empty. That slot sends idle.
- R7: `tx_done_irq` sets when the TX side disables itself. It clears on the next write to `cfg_addr` 5.
- R8: A received byte matches if it equals the expected idle byte. The expectation starts at byte 0 and alternates after each match. The first N consecutive matches are stored and later ones are dropped, where N is written at `cfg_addr` 2 and resets to 2. A mismatching byte, or a chip-select assertion, restarts the count and the expectation.
- R9: A byte that should be stored while the RX FIFO is full is dropped and sets sticky `ovf_err`. Stored bytes are kept.
- R10: Chip select deasserting with a partial byte shifted sets sticky `frame_err` and restarts bit counting. A write to `cfg_addr` 6 clears `frame_err` with bit 0 and `ovf_err` with bit 1.
- R11: `tx_irq` is high while the TX level is at or below the threshold at `cfg_addr` 3 (reset 0). `rx_irq` is high while the RX threshold at `cfg_addr` 4 (reset 1) is non-zero and the RX level is at or above it.
- R12: After reset both FIFOs are empty, `tx_en`, `tx_done_irq`, `frame_err` and `ovf_err` are low, and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock from the host |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| tx_push | input | 1 | Push `tx_wdata` into the TX FIFO |
| tx_wdata | input | 8 | Byte to transmit |
| rx_pop | input | 1 | Remove the oldest RX byte |
| rx_rdata | output | 8 | Oldest RX byte |
| tx_count | output | clog2(DEPTH)+1 | TX FIFO fill level |
| rx_count | output | clog2(DEPTH)+1 | RX FIFO fill level |
| tx_en | output | 1 | TX FIFO enabled |
| tx_irq | output | 1 | TX level at or below threshold |
| tx_done_irq | output | 1 | TX side disabled itself |
| rx_irq | output | 1 | RX level at or above threshold |
| frame_err | output | 1 | Sticky framing error |
| ovf_err | output | 1 | Sticky RX overflow |

## Verification
The receive path is driven with three kinds of byte stream, and each one separates a different behaviour:
- Plain data bytes show that capture and ordering work.
- Exact idle-pattern runs, interrupted by a data byte, show where the repeat filter starts and stops dropping.
- Idle bytes arriving out of phase show that a match depends on the alternating expectation and not merely on the byte value.

MOSI changes mid-way through the high phase of SCK, so a slave that sampled on the rising edge would capture the previous bit.

The transmit path is exercised with the FIFO disabled, with data followed by drain, and with an enable issued on an empty FIFO. Together these expose the idle phase order, its restart on chip select, and the self-disable timing. A truncated byte, an overfilled receive FIFO and threshold crossings cover the error and interrupt flags.

// File: rtl/spis_pkg.sv
package spis_pkg;
   typedef enum logic [2:0] {
      CFG_IDLE0 = 3'd0,
      CFG_IDLE1 = 3'd1,
      CFG_RPT   = 3'd2,
      CFG_TXTHR = 3'd3,
      CFG_RXTHR = 3'd4,
      CFG_TXEN  = 3'd5,
      CFG_CLR   = 3'd6
   } cfg_addr_e;

   function automatic logic [7:0] idle_pick(input logic ph, input logic [7:0] b0,
                                            input logic [7:0] b1);
      return ph ? b1 : b0;
   endfunction
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
   parameter int           N       = 1,
   parameter int           STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   initial assert (STAGES >= 1) else $error("spis_sync: STAGES must be at least 1");

   generate
      if (STAGES == 1) begin : g_one
         logic [N-1:0] st;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st <= RST_VAL;
            else        st <= d;
         assign q = st;
      end else begin : g_chain
         logic [STAGES-1:0][N-1:0] st;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st <= {STAGES{RST_VAL}};
            else        st <= {st[STAGES-2:0], d};
         assign q = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spis_fifo.sv
module spis_fifo #(
   parameter  int W     = 8,
   parameter  int DEPTH = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   initial assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
      else $error("spis_fifo: DEPTH must be a power of two >= 2");

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign full    = (count == FULL_CNT);
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk)
      if (do_push) mem[wr_ptr] <= din;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + AW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end

   // R9
   fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);
   // R9
   fifo_hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop) |=> full);
endmodule

// File: rtl/spi_idle_slave.sv
module spi_idle_slave #(
   parameter int         DEPTH       = 1024,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] IDLE0_RST   = 8'hA7,
   parameter logic [7:0] IDLE1_RST   = 8'hB4,
   parameter logic [7:0] RPT_RST     = 8'd2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sck,
   input  logic                      cs_n,
   input  logic                      mosi,
   output logic                      miso,
   input  logic                      cfg_we,
   input  logic [2:0]                cfg_addr,
   input  logic [15:0]               cfg_wdata,
   input  logic                      tx_push,
   input  logic [7:0]                tx_wdata,
   input  logic                      rx_pop,
   output logic [7:0]                rx_rdata,
   output logic [$clog2(DEPTH):0]    tx_count,
   output logic [$clog2(DEPTH):0]    rx_count,
   output logic                      tx_en,
   output logic                      tx_irq,
   output logic                      tx_done_irq,
   output logic                      rx_irq,
   output logic                      frame_err,
   output logic                      ovf_err
);
   import spis_pkg::*;

   localparam int CW = $clog2(DEPTH) + 1;

   initial assert (CW <= 16) else $error("spi_idle_slave: DEPTH too large for cfg_wdata");

   // input conditioning
   logic sck_s, cs_s, mosi_s, sck_q, cs_q;
   spis_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sck, cs_n, mosi}), .q({sck_s, cs_s, mosi_s}));

   logic active, sck_rise, sck_fall, cs_fall, cs_rise;
   assign active   = !cs_s;
   assign sck_rise = sck_s && !sck_q;
   assign sck_fall = !sck_s && sck_q;
   assign cs_fall  = !cs_s && cs_q;
   assign cs_rise  = cs_s && !cs_q;

   // configuration registers
   logic [7:0]    idle0, idle1, rpt_lim;
   logic [CW-1:0] tx_thr, rx_thr;
   logic          wr_txen, wr_clr;
   assign wr_txen = cfg_we && (cfg_addr == CFG_TXEN) && cfg_wdata[0];
   assign wr_clr  = cfg_we && (cfg_addr == CFG_CLR);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         idle0   <= IDLE0_RST;
         idle1   <= IDLE1_RST;
         rpt_lim <= RPT_RST;
         tx_thr  <= '0;
         rx_thr  <= CW'(1);
      end else if (cfg_we) begin
         case (cfg_addr)
            CFG_IDLE0: idle0   <= cfg_wdata[7:0];
            CFG_IDLE1: idle1   <= cfg_wdata[7:0];
            CFG_RPT:   rpt_lim <= cfg_wdata[7:0];
            CFG_TXTHR: tx_thr  <= cfg_wdata[CW-1:0];
            CFG_RXTHR: rx_thr  <= cfg_wdata[CW-1:0];
            default: ;
         endcase
      end

   // FIFOs
   logic       tx_pop, tx_full, tx_empty, rx_push, rx_full, rx_empty;
   logic [7:0] tx_head, rx_byte;

   spis_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_wdata), .pop(tx_pop),
      .dout(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty));

   spis_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte), .pop(rx_pop),
      .dout(rx_rdata), .count(rx_count), .full(rx_full), .empty(rx_empty));

   // shift engine
   logic [2:0] bit_cnt;
   logic [7:0] tx_sh, rx_sh, rpt_cnt;
   logic       idle_ph, rx_ph, load, use_fifo, byte_done, match, keep, tx_off;
   logic [7:0] tx_next;

   assign load      = active && !cs_fall && sck_rise && (bit_cnt == 3'd0);
   assign use_fifo  = tx_en && !tx_empty;
   assign tx_pop    = load && use_fifo;
   assign tx_next   = use_fifo ? tx_head : idle_pick(idle_ph, idle0, idle1);
   assign byte_done = active && !cs_fall && sck_fall && (bit_cnt == 3'd7);
   assign rx_byte   = {rx_sh[6:0], mosi_s};
   assign match     = (rx_byte == idle_pick(rx_ph, idle0, idle1));
   assign keep      = !match || (rpt_cnt < rpt_lim);
   assign rx_push   = byte_done && keep && !rx_full;
   assign tx_off    = !tx_push && ((tx_pop && tx_count == CW'(1)) ||
                                   (load && tx_en && tx_empty));
   assign miso      = tx_sh[7];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         sck_q <= 1'b0;  cs_q  <= 1'b1;
         bit_cnt <= '0;  tx_sh <= '0;  rx_sh <= '0;
         idle_ph <= 1'b0; rx_ph <= 1'b0; rpt_cnt <= '0;
      end else begin
         sck_q <= sck_s;
         cs_q  <= cs_s;
         if (cs_fall) begin
            bit_cnt <= '0;  idle_ph <= 1'b0;  rx_ph <= 1'b0;  rpt_cnt <= '0;
         end else if (cs_rise) begin
            bit_cnt <= '0;
         end else if (active) begin
            if (sck_rise) begin
               if (bit_cnt == 3'd0) begin
                  tx_sh <= tx_next;
                  if (!use_fifo) idle_ph <= !idle_ph;
               end else begin
                  tx_sh <= {tx_sh[6:0], 1'b0};
               end
            end
            if (sck_fall) begin
               rx_sh   <= rx_byte;
               bit_cnt <= bit_cnt + 3'd1;
               if (bit_cnt == 3'd7) begin
                  if (match) begin
                     rx_ph <= !rx_ph;
                     if (rpt_cnt != 8'hFF) rpt_cnt <= rpt_cnt + 8'd1;
                  end else begin
                     rx_ph   <= 1'b0;
                     rpt_cnt <= '0;
                  end
               end
            end
         end
      end

   // status flags
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         tx_en <= 1'b0; tx_done_irq <= 1'b0; frame_err <= 1'b0; ovf_err <= 1'b0;
      end else begin
         if (wr_txen)     begin tx_en <= 1'b1; tx_done_irq <= 1'b0; end
         else if (tx_off) begin tx_en <= 1'b0; tx_done_irq <= 1'b1; end
         if (cs_rise && bit_cnt != 3'd0)      frame_err <= 1'b1;
         else if (wr_clr && cfg_wdata[0])     frame_err <= 1'b0;
         if (byte_done && keep && rx_full)    ovf_err <= 1'b1;
         else if (wr_clr && cfg_wdata[1])     ovf_err <= 1'b0;
      end

   assign tx_irq = (tx_count <= tx_thr);
   assign rx_irq = (rx_thr != '0) && (rx_count >= rx_thr);

   // R1
   miso_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sck_rise) |-> $stable(miso));
   // R6
   tx_off_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_en) |-> (tx_count == '0));
   // R7
   tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done_irq) |-> !tx_en);
   // R10
   frame_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_err) |-> $past(cs_rise));
endmodule

// File: tb/sim_spi_idle_slave.sv
module sim_spi_idle_slave;
   localparam int DEPTH = 8;
   localparam int CW    = $clog2(DEPTH) + 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso;
   logic cfg_we = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic tx_push = 1'b0, rx_pop = 1'b0;
   logic [7:0] tx_wdata = '0, rx_rdata;
   logic [CW-1:0] tx_count, rx_count;
   logic tx_en, tx_irq, tx_done_irq, rx_irq, frame_err, ovf_err;

   int total = 0, bad = 0;

   always #4 clk = ~clk;

   spi_idle_slave #(.DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
      .tx_count(tx_count), .rx_count(rx_count), .tx_en(tx_en), .tx_irq(tx_irq),
      .tx_done_irq(tx_done_irq), .rx_irq(rx_irq), .frame_err(frame_err), .ovf_err(ovf_err));

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg_wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic push_tx(input logic [7:0] b);
      @(negedge clk); tx_push = 1'b1; tx_wdata = b;
      @(negedge clk); tx_push = 1'b0;
   endtask

   task automatic pop_rx(input string tag, input logic [7:0] exp);
      @(negedge clk); check(tag, {8'h00, rx_rdata}, {8'h00, exp});
      rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
   endtask

   task automatic cs_on;
      @(negedge clk); cs_n = 1'b0; wait_clk(8);
   endtask

   task automatic cs_off;
      wait_clk(4); cs_n = 1'b1; wait_clk(8);
   endtask

   // one bit: rise, MOSI moves while SCK high, MISO sampled before fall
   task automatic spi_bits(input logic [7:0] dout, input int nbits, output logic [7:0] din);
      din = '0;
      for (int i = 7; i > 7 - nbits; i--) begin
         @(negedge clk); sck = 1'b1;
         wait_clk(3); mosi = dout[i];
         wait_clk(5); din[i] = miso; sck = 1'b0;
         wait_clk(8);
      end
   endtask

   task automatic xfer(input logic [7:0] dout, output logic [7:0] din);
      spi_bits(dout, 8, din);
   endtask

   task automatic t_reset;
      check("R12 rx_count", 16'(rx_count), 16'd0);
      check("R12 tx_count", 16'(tx_count), 16'd0);
      check("R12 flags", {12'd0, tx_en, tx_done_irq, frame_err, ovf_err}, 16'h0);
      check("R12 miso", 16'(miso), 16'd0);
      check("R11 reset irqs", {14'd0, tx_irq, rx_irq}, 16'b10);
   endtask

   task automatic t_idle;
      logic [7:0] r;
      cs_on;
      xfer(8'h11, r); check("R3 idle byte0", 16'(r), 16'h00A7);
      xfer(8'h22, r); check("R3 idle byte1", 16'(r), 16'h00B4);
      xfer(8'h33, r); check("R3 idle wrap",  16'(r), 16'h00A7);
      cs_off;
      cs_on;
      xfer(8'h44, r); check("R4 phase restart", 16'(r), 16'h00A7);
      cs_off;
      check("R2 rx count", 16'(rx_count), 16'd4);
      check("R11 rx_irq on", 16'(rx_irq), 16'd1);
      pop_rx("R1 R2 rx0", 8'h11);
      pop_rx("R2 rx1", 8'h22);
      pop_rx("R2 rx2", 8'h33);
      pop_rx("R2 rx3", 8'h44);
      check("R2 rx drained", 16'(rx_count), 16'd0);
   endtask

   task automatic t_txdata;
      logic [7:0] r;
      push_tx(8'h5A); push_tx(8'hC3);
      check("R11 tx_irq off", 16'(tx_irq), 16'd0);
      cfg_wr(3'd5, 16'h1);
      check("R5 tx_en set", 16'(tx_en), 16'd1);
      cs_on;
      xfer(8'h01, r); check("R5 tx data0", 16'(r), 16'h005A);
      xfer(8'h02, r); check("R5 tx data1", 16'(r), 16'h00C3);
      check("R6 tx_en dropped", 16'(tx_en), 16'd0);
      check("R7 done set", 16'(tx_done_irq), 16'd1);
      xfer(8'h03, r); check("R4 idle after data", 16'(r), 16'h00A7);
      cfg_wr(3'd5, 16'h1);
      check("R7 done cleared", 16'(tx_done_irq), 16'd0);
      xfer(8'h04, r); check("R6 empty enable idles", 16'(r), 16'h00B4);
      check("R6 empty enable drops", 16'(tx_en), 16'd0);
      check("R7 done again", 16'(tx_done_irq), 16'd1);
      cs_off;
      for (int i = 1; i <= 4; i++) pop_rx("R2 duplex rx", 8'(i));
   endtask

   task automatic t_filter;
      logic [7:0] r;
      cfg_wr(3'd2, 16'd2);
      cs_on;
      xfer(8'hA7, r); xfer(8'hB4, r); xfer(8'hA7, r); xfer(8'hB4, r);
      xfer(8'h55, r); xfer(8'hA7, r);
      cs_off;
      check("R8 stored count", 16'(rx_count), 16'd4);
      pop_rx("R8 keep0", 8'hA7);
      pop_rx("R8 keep1", 8'hB4);
      pop_rx("R8 breaker", 8'h55);
      pop_rx("R8 restart", 8'hA7);
      cfg_wr(3'd2, 16'd0);
      cs_on;
      xfer(8'hA7, r); xfer(8'hB4, r);
      check("R8 limit zero drops", 16'(rx_count), 16'd0);
      xfer(8'hB4, r);
      cs_off;
      check("R8 out of phase kept", 16'(rx_count), 16'd1);
      pop_rx("R8 out of phase byte", 8'hB4);
      cfg_wr(3'd2, 16'd2);
   endtask

   task automatic t_ovf;
      logic [7:0] r;
      cs_on;
      for (int i = 0; i < DEPTH + 1; i++) xfer(8'h10 + 8'(i), r);
      cs_off;
      check("R9 ovf set", 16'(ovf_err), 16'd1);
      check("R9 count full", 16'(rx_count), 16'(DEPTH));
      for (int i = 0; i < DEPTH; i++) pop_rx("R9 kept data", 8'h10 + 8'(i));
      cfg_wr(3'd6, 16'h2);
      check("R10 ovf cleared", 16'(ovf_err), 16'd0);
   endtask

   task automatic t_frame;
      logic [7:0] r;
      cs_on;
      spi_bits(8'hF0, 4, r);
      cs_off;
      check("R10 frame set", 16'(frame_err), 16'd1);
      check("R10 no partial push", 16'(rx_count), 16'd0);
      cfg_wr(3'd6, 16'h1);
      check("R10 frame cleared", 16'(frame_err), 16'd0);
      cs_on;
      xfer(8'h66, r);
      cs_off;
      check("R10 clean after", 16'(frame_err), 16'd0);
      pop_rx("R10 realigned", 8'h66);
   endtask

   task automatic t_custom;
      logic [7:0] r;
      cfg_wr(3'd0, 16'h3C);
      cfg_wr(3'd1, 16'hC3);
      cs_on;
      xfer(8'h01, r); check("R3 custom idle0", 16'(r), 16'h003C);
      xfer(8'h02, r); check("R3 custom idle1", 16'(r), 16'h00C3);
      cs_off;
      pop_rx("R2 custom rx0", 8'h01);
      pop_rx("R2 custom rx1", 8'h02);
   endtask

   task automatic t_thr;
      logic [7:0] r;
      cfg_wr(3'd4, 16'd3);
      cs_on;
      xfer(8'h01, r); xfer(8'h02, r);
      check("R11 rx below thr", 16'(rx_irq), 16'd0);
      xfer(8'h03, r);
      cs_off;
      check("R11 rx at thr", 16'(rx_irq), 16'd1);
      cfg_wr(3'd3, 16'd1);
      push_tx(8'hEE);
      check("R11 tx at thr", 16'(tx_irq), 16'd1);
      push_tx(8'hEF);
      check("R11 tx above thr", 16'(tx_irq), 16'd0);
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);
      t_reset;
      t_idle;
      t_txdata;
      t_filter;
      t_ovf;
      t_frame;
      t_custom;
      t_thr;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule